// File: doc/BRIEF.md
# Two-Level Debug Breakpoint Trigger

This block watches a processor's instruction-fetch bus and its operand-access bus and emits a one-cycle trigger pulse to the halt controller whenever a programmed debug condition is met. Four program-counter comparators check each fetch address. The first of them has a bit mask, and the other three compare exactly. Two comparator sets check operand accesses. Each set has an inclusive address window with attribute checks and a masked data comparator. When enabled, the data comparator must also match before the address match counts.

Each of the two trigger levels is the OR of two terms: the program-counter term and its own set's address term, with optional data qualification. The level-one condition uses set 0 and the level-two condition uses set 1. In single-level mode, a level-one hit raises the trigger directly. In two-level mode, a level-one hit only arms level two. The pulse is issued when the level-two condition later holds, and the sequencer then returns to level one.

All configuration goes through a simple register write port, addressed by index:

| Index | Register |
|---|---|
| 0 to 3 | PC comparator values |
| 4 | PC0 mask |
| 5 to 9 | set 0: high bound, low bound, attributes, data value, data mask |
| 10 to 14 | set 1, same order |
| 15 | control |

Top module: `dbg_trig_unit`

## Requirements
- R1: Each fetch (`fetch_vld`=1) whose address exactly equals one of PC comparator values 1 to 3 raises the PC term. A fetch address differing in any bit does not raise it.
- R2: PC comparator 0 ignores every bit set to 1 in the PC0 mask register (index 4) and compares all other bits exactly.
- R3: The PC term is evaluated on fetches only. An operand access whose address equals a PC comparator value does not raise it.
- R4: A set's address term requires an operand access (`op_vld`=1) with low bound <= address <= high bound, inclusive at both ends. Fetches never raise it.
- R5: Attribute register bits are: [0] expected write flag, [2:1] expected size, [3] enable write-flag check, [4] enable size check. An enabled check must match `op_wr` or `op_size` respectively, and a disabled check is ignored.
- R6: The data comparator matches when `op_data` equals the data value in every bit where the data mask is 0. The data comparator gates the address term only when that level's data-qualify bit is set, and has no effect otherwise.
- R7: Control register bits are: [0] arm, [1] two-level mode, [2] level-one PC enable, [3] level-one address enable, [4] level-one data qualify, [5] level-two PC enable, [6] level-two address enable, [7] level-two data qualify. In single-level armed mode, `trig_o` is high for exactly the cycle after a bus cycle that meets the level-one condition, and a cycle with no bus activity never leads to a trigger.
- R8: In two-level mode, a level-one hit produces no pulse and arms level two. A level-two condition before that, or in the same cycle as the level-one hit, is ignored. A level-two hit while armed gives a one-cycle pulse and returns the sequencer to level one.
- R9: Any write to the control register returns the sequencer to level one. While arm is 0, no trigger is produced.
- R10: Synchronous reset clears every register to zero and the sequencer to level one, and `trig_o` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| fetch_vld | input | 1 | Instruction fetch this cycle |
| fetch_pc | input | 32 | Fetch address |
| op_vld | input | 1 | Operand access this cycle |
| op_addr | input | 32 | Operand address |
| op_data | input | 32 | Operand data |
| op_wr | input | 1 | Operand access is a write |
| op_size | input | 2 | Operand access size code |
| trig_o | output | 1 | One-cycle debug trigger to the halt controller |

## Verification
The bench probes both ends of the address window and the addresses one past each end. A window compare that is off by one, or exclusive at either end, fails at exactly those points. It drives a PC value on the operand bus and a window address on the fetch bus, which exposes any cross-wiring between the two buses. It toggles the data-qualify bit so that both a data comparator ignored when enabled and one applied when disabled are visible. In two-level mode it presents the level-two condition first, and then together with the level-one hit. A sequencer that skips the level-one gate, or checks level two in the same cycle, pulses too early. The bench also follows a pulse with a second level-two hit, and rewrites control while level two is armed, to catch a sequencer that does not return to level one.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    localparam int DBG_AW       = 32;
    localparam int DBG_DW       = 32;
    localparam int DBG_NPC      = 4;
    localparam int DBG_NLVL     = 2;
    localparam int DBG_SET_REGS = 5;

    // register offsets inside one comparator set
    localparam int SO_HI    = 0;
    localparam int SO_LO    = 1;
    localparam int SO_ATTR  = 2;
    localparam int SO_DVAL  = 3;
    localparam int SO_DMASK = 4;

    typedef enum logic {
        LVL_ONE = 1'b0,
        LVL_TWO = 1'b1
    } lvl_e;

    // bit 0 = arm ... bit 7 = level-two data qualify
    typedef struct packed {
        logic l2_dq;
        logic l2_addr;
        logic l2_pc;
        logic l1_dq;
        logic l1_addr;
        logic l1_pc;
        logic two_lvl;
        logic arm;
    } ctrl_t;

    typedef struct packed {
        logic       chk_size;
        logic       chk_wr;
        logic [1:0] size;
        logic       wr;
    } attr_t;

    function automatic logic attr_ok(attr_t a, logic wr, logic [1:0] sz);
        return (!a.chk_wr || (a.wr == wr)) && (!a.chk_size || (a.size == sz));
    endfunction

    function automatic int set_base(int npc, int s);
        return npc + 1 + DBG_SET_REGS * s;
    endfunction

endpackage

// File: rtl/dbg_pc_match.sv
module dbg_pc_match
    import dbg_trig_pkg::*;
#(
    parameter int AW  = DBG_AW,
    parameter int NPC = DBG_NPC
) (
    input  logic          fetch_vld,
    input  logic [AW-1:0] fetch_pc,
    input  logic [AW-1:0] pc_val [NPC],
    input  logic [AW-1:0] pc_mask,
    output logic          pc_hit
);

    logic [NPC-1:0] cmp_hit;

    for (genvar i = 0; i < NPC; i++) begin : g_cmp
        if (i == 0) begin : g_masked
            assign cmp_hit[i] = ((fetch_pc ^ pc_val[i]) & ~pc_mask) == '0;
        end else begin : g_exact
            assign cmp_hit[i] = (fetch_pc == pc_val[i]);
        end
    end

    assign pc_hit = fetch_vld && (|cmp_hit);

endmodule

// File: rtl/dbg_addr_data_match.sv
module dbg_addr_data_match
    import dbg_trig_pkg::*;
#(
    parameter int AW = DBG_AW,
    parameter int DW = DBG_DW
) (
    input  logic          acc_vld,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_data,
    input  logic          acc_wr,
    input  logic [1:0]    acc_size,
    input  logic [AW-1:0] lo_bound,
    input  logic [AW-1:0] hi_bound,
    input  attr_t         attr,
    input  logic [DW-1:0] dval,
    input  logic [DW-1:0] dmask,
    output logic          addr_hit,
    output logic          data_hit
);

    logic in_window;
    logic attr_hit;

    always_comb begin
        in_window = (acc_addr >= lo_bound) && (acc_addr <= hi_bound);
        attr_hit  = attr_ok(attr, acc_wr, acc_size);
        addr_hit  = acc_vld && in_window && attr_hit;
        data_hit  = acc_vld && (((acc_data ^ dval) & ~dmask) == '0);
    end

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
    import dbg_trig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic arm,
    input  logic two_lvl,
    input  logic l1_hit,
    input  logic l2_hit,
    output lvl_e lvl,
    output logic trig
);

    lvl_e lvl_q;
    logic trig_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lvl_q  <= LVL_ONE;
            trig_q <= 1'b0;
        end else begin
            trig_q <= 1'b0;
            if (!arm) begin
                lvl_q <= LVL_ONE;
            end else begin
                unique case (lvl_q)
                    LVL_ONE: begin
                        if (l1_hit) begin
                            if (two_lvl) lvl_q  <= LVL_TWO;
                            else         trig_q <= 1'b1;
                        end
                    end
                    LVL_TWO: begin
                        if (l2_hit) begin
                            trig_q <= 1'b1;
                            lvl_q  <= LVL_ONE;
                        end
                    end
                    default: lvl_q <= LVL_ONE;
                endcase
            end
        end
    end

    assign lvl  = lvl_q;
    assign trig = trig_q;

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
    import dbg_trig_pkg::*;
#(
    parameter  int AW   = DBG_AW,
    parameter  int DW   = DBG_DW,
    parameter  int NPC  = DBG_NPC,
    localparam int WW   = (AW > DW) ? AW : DW,
    localparam int NREG = NPC + 1 + DBG_SET_REGS * DBG_NLVL + 1,
    localparam int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [WW-1:0] cfg_wdata,
    input  logic          fetch_vld,
    input  logic [AW-1:0] fetch_pc,
    input  logic          op_vld,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_data,
    input  logic          op_wr,
    input  logic [1:0]    op_size,
    output logic          trig_o
);

    localparam int NLVL     = DBG_NLVL;
    localparam int MASK_IDX = NPC;
    localparam int CTRL_IDX = NREG - 1;

    logic [AW-1:0] pc_val_q [NPC];
    logic [AW-1:0] pc_mask_q;
    logic [AW-1:0] hi_q     [NLVL];
    logic [AW-1:0] lo_q     [NLVL];
    attr_t         attr_q   [NLVL];
    logic [DW-1:0] dval_q   [NLVL];
    logic [DW-1:0] dmask_q  [NLVL];
    ctrl_t         ctrl_q;

    logic            ctrl_wr;
    logic            pc_hit;
    logic [NLVL-1:0] addr_hit;
    logic [NLVL-1:0] data_hit;
    logic [NLVL-1:0] lvl_pc_en;
    logic [NLVL-1:0] lvl_addr_en;
    logic [NLVL-1:0] lvl_dq;
    logic [NLVL-1:0] lvl_hit;
    lvl_e            lvl;

    assign ctrl_wr = cfg_we && (cfg_idx == IW'(CTRL_IDX));

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPC; i++) pc_val_q[i] <= '0;
            pc_mask_q <= '0;
            for (int s = 0; s < NLVL; s++) begin
                hi_q[s]    <= '0;
                lo_q[s]    <= '0;
                attr_q[s]  <= '0;
                dval_q[s]  <= '0;
                dmask_q[s] <= '0;
            end
            ctrl_q <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NPC; i++) begin
                if (cfg_idx == IW'(i)) pc_val_q[i] <= cfg_wdata[AW-1:0];
            end
            if (cfg_idx == IW'(MASK_IDX)) pc_mask_q <= cfg_wdata[AW-1:0];
            for (int s = 0; s < NLVL; s++) begin
                if (cfg_idx == IW'(set_base(NPC, s) + SO_HI))    hi_q[s]    <= cfg_wdata[AW-1:0];
                if (cfg_idx == IW'(set_base(NPC, s) + SO_LO))    lo_q[s]    <= cfg_wdata[AW-1:0];
                if (cfg_idx == IW'(set_base(NPC, s) + SO_ATTR))  attr_q[s]  <= attr_t'(cfg_wdata[$bits(attr_t)-1:0]);
                if (cfg_idx == IW'(set_base(NPC, s) + SO_DVAL))  dval_q[s]  <= cfg_wdata[DW-1:0];
                if (cfg_idx == IW'(set_base(NPC, s) + SO_DMASK)) dmask_q[s] <= cfg_wdata[DW-1:0];
            end
            if (ctrl_wr) ctrl_q <= ctrl_t'(cfg_wdata[$bits(ctrl_t)-1:0]);
        end
    end

    dbg_pc_match #(
        .AW  (AW),
        .NPC (NPC)
    ) u_pc (
        .fetch_vld (fetch_vld),
        .fetch_pc  (fetch_pc),
        .pc_val    (pc_val_q),
        .pc_mask   (pc_mask_q),
        .pc_hit    (pc_hit)
    );

    assign lvl_pc_en   = {ctrl_q.l2_pc,   ctrl_q.l1_pc};
    assign lvl_addr_en = {ctrl_q.l2_addr, ctrl_q.l1_addr};
    assign lvl_dq      = {ctrl_q.l2_dq,   ctrl_q.l1_dq};

    for (genvar s = 0; s < NLVL; s++) begin : g_set
        dbg_addr_data_match #(
            .AW (AW),
            .DW (DW)
        ) u_ad (
            .acc_vld  (op_vld),
            .acc_addr (op_addr),
            .acc_data (op_data),
            .acc_wr   (op_wr),
            .acc_size (op_size),
            .lo_bound (lo_q[s]),
            .hi_bound (hi_q[s]),
            .attr     (attr_q[s]),
            .dval     (dval_q[s]),
            .dmask    (dmask_q[s]),
            .addr_hit (addr_hit[s]),
            .data_hit (data_hit[s])
        );

        assign lvl_hit[s] = (lvl_pc_en[s] && pc_hit)
                         || (lvl_addr_en[s] && addr_hit[s] && (!lvl_dq[s] || data_hit[s]));
    end

    dbg_trig_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctrl_wr),
        .arm     (ctrl_q.arm),
        .two_lvl (ctrl_q.two_lvl),
        .l1_hit  (lvl_hit[0]),
        .l2_hit  (lvl_hit[1]),
        .lvl     (lvl),
        .trig    (trig_o)
    );

endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk
    import dbg_trig_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic trig,
    input logic arm,
    input logic two_lvl,
    input logic ctrl_wr,
    input logic fetch_vld,
    input logic op_vld,
    input logic l1_hit,
    input lvl_e lvl
);

    // R10: reset leaves no trigger and level one selected
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!trig && lvl == LVL_ONE));

    // R9: disarmed block stays quiet
    p_quiet_disarmed_r9: assert property (@(posedge clk) disable iff (rst)
        !arm |=> !trig);

    // R9: control write restarts the sequencer
    p_ctrl_restart_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (!trig && lvl == LVL_ONE));

    // R7: no bus activity, no trigger
    p_idle_bus_r7: assert property (@(posedge clk) disable iff (rst)
        (!fetch_vld && !op_vld) |=> !trig);

    // R8: in two-level mode a pulse lasts one cycle
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (trig && two_lvl) |=> !trig);

    // R8: level two is entered only from an armed level-one hit
    p_l2_entry_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(lvl == LVL_TWO) |-> ($past(l1_hit) && $past(two_lvl) && $past(arm)));

endmodule

bind dbg_trig_unit dbg_trig_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig_o),
    .arm       (ctrl_q.arm),
    .two_lvl   (ctrl_q.two_lvl),
    .ctrl_wr   (ctrl_wr),
    .fetch_vld (fetch_vld),
    .op_vld    (op_vld),
    .l1_hit    (lvl_hit[0]),
    .lvl       (lvl)
);

// File: tb/sim_dbg_trig_unit.sv
module sim_dbg_trig_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        fetch_vld = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        op_vld = 1'b0;
    logic [31:0] op_addr = '0;
    logic [31:0] op_data = '0;
    logic        op_wr = 1'b0;
    logic [1:0]  op_size = '0;
    logic        trig_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dbg_trig_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .fetch_vld (fetch_vld),
        .fetch_pc  (fetch_pc),
        .op_vld    (op_vld),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .op_wr     (op_wr),
        .op_size   (op_size),
        .trig_o    (trig_o)
    );

    typedef struct packed {
        logic        iv;
        logic [31:0] pc;
        logic        ov;
        logic [31:0] ad;
        logic [31:0] dt;
        logic        wr;
        logic [1:0]  sz;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    // single-level configuration, see initial block
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h0000_1000, 1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 1'b1, 4'd2},      // R2 PC0 base
        '{1'b1, 32'h0000_100F, 1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 1'b1, 4'd2},      // R2 masked low bits
        '{1'b1, 32'h0000_1010, 1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 4'd2},      // R2 bit outside mask
        '{1'b1, 32'h0000_2000, 1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 1'b1, 4'd1},      // R1 PC1
        '{1'b1, 32'h0000_4000, 1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 1'b1, 4'd1},      // R1 PC3
        '{1'b1, 32'h0000_2001, 1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 4'd1},      // R1 exact only
        '{1'b0, 32'h0,         1'b1, 32'h0000_2000, 32'h0, 1'b1, 2'd0, 1'b0, 4'd3}, // R3 PC on operand bus
        '{1'b0, 32'h0,         1'b1, 32'h0000_8000, 32'h0, 1'b1, 2'd0, 1'b1, 4'd4}, // R4 low bound
        '{1'b0, 32'h0,         1'b1, 32'h0000_80FF, 32'h0, 1'b1, 2'd0, 1'b1, 4'd4}, // R4 high bound
        '{1'b0, 32'h0,         1'b1, 32'h0000_8100, 32'h0, 1'b1, 2'd0, 1'b0, 4'd4}, // R4 above
        '{1'b0, 32'h0,         1'b1, 32'h0000_7FFF, 32'h0, 1'b1, 2'd0, 1'b0, 4'd4}, // R4 below
        '{1'b0, 32'h0,         1'b1, 32'h0000_8010, 32'h0, 1'b0, 2'd0, 1'b0, 4'd5}, // R5 read rejected
        '{1'b1, 32'h0000_8010, 1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 4'd4},      // R4 fetch ignored
        '{1'b0, 32'h0,         1'b1, 32'h0000_8010, 32'h0, 1'b1, 2'd0, 1'b1, 4'd6}, // R6 data ignored
        '{1'b0, 32'h0,         1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0, 4'd7}       // R7 idle
    };

    task automatic cfg_write(input int idx, input logic [31:0] val);
        cfg_we    = 1'b1;
        cfg_idx   = 4'(idx);
        cfg_wdata = val;
        @(posedge clk);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic step(input logic iv, input logic [31:0] pc, input logic ov,
                        input logic [31:0] ad, input logic [31:0] dt, input logic wr,
                        input logic [1:0] sz, input logic exp, input string tag);
        fetch_vld = iv;
        fetch_pc  = pc;
        op_vld    = ov;
        op_addr   = ad;
        op_data   = dt;
        op_wr     = wr;
        op_size   = sz;
        @(posedge clk);
        @(negedge clk);
        fetch_vld = 1'b0;
        op_vld    = 1'b0;
        checks++;
        if (trig_o !== exp) begin
            fails++;
            $display("FAIL %s: trig=%0b expected=%0b", tag, trig_o, exp);
        end
    endtask

    task automatic fetch(input logic [31:0] pc, input logic exp, input string tag);
        step(1'b1, pc, 1'b0, 32'h0, 32'h0, 1'b0, 2'd0, exp, tag);
    endtask

    task automatic opacc(input logic [31:0] ad, input logic [31:0] dt, input logic wr,
                         input logic [1:0] sz, input logic exp, input string tag);
        step(1'b0, 32'h0, 1'b1, ad, dt, wr, sz, exp, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (trig_o !== 1'b0) begin
            fails++;
            $display("FAIL R10 reset: trig=%0b expected=0", trig_o);
        end

        // single-level setup
        cfg_write(0, 32'h0000_1000);
        cfg_write(4, 32'h0000_000F);
        cfg_write(1, 32'h0000_2000);
        cfg_write(2, 32'h0000_3000);
        cfg_write(3, 32'h0000_4000);
        cfg_write(5, 32'h0000_80FF);   // set0 high
        cfg_write(6, 32'h0000_8000);   // set0 low
        cfg_write(7, 32'h0000_0009);   // check write flag, expect write
        cfg_write(8, 32'hA5A5_0000);
        cfg_write(9, 32'h0000_FFFF);
        cfg_write(15, 32'h0000_000D);  // arm, l1 pc, l1 addr

        for (int k = 0; k < NV; k++) begin
            step(VEC[k].iv, VEC[k].pc, VEC[k].ov, VEC[k].ad, VEC[k].dt, VEC[k].wr,
                 VEC[k].sz, VEC[k].exp, $sformatf("R%0d vec %0d", VEC[k].req, k));
        end

        // R6: data qualification enabled
        cfg_write(15, 32'h0000_001D);
        opacc(32'h0000_8010, 32'hA5A5_1234, 1'b1, 2'd0, 1'b1, "R6 data match under mask");
        opacc(32'h0000_8010, 32'hA5A4_0000, 1'b1, 2'd0, 1'b0, "R6 data mismatch");

        // R5: size check enabled, expect size 2
        cfg_write(7, 32'h0000_001D);
        opacc(32'h0000_8010, 32'hA5A5_0000, 1'b1, 2'd2, 1'b1, "R5 size match");
        opacc(32'h0000_8010, 32'hA5A5_0000, 1'b1, 2'd1, 1'b0, "R5 size mismatch");

        // R7: back-to-back hits in single-level mode each pulse
        fetch(32'h0000_3000, 1'b1, "R7 hit one");
        fetch(32'h0000_3000, 1'b1, "R7 hit two");

        // R8: two-level, l1 = set0 address, l2 = PC
        cfg_write(15, 32'h0000_002B);
        fetch(32'h0000_2000, 1'b0, "R8 level two before level one");
        step(1'b1, 32'h0000_2000, 1'b1, 32'h0000_8010, 32'h0, 1'b1, 2'd2, 1'b0,
             "R8 both conditions same cycle");
        fetch(32'h0000_2000, 1'b1, "R8 level two after level one");
        fetch(32'h0000_2000, 1'b0, "R8 back at level one");

        // R8: l1 = PC, l2 = set1 address
        cfg_write(10, 32'h0000_9000);
        cfg_write(11, 32'h0000_9000);
        cfg_write(15, 32'h0000_0047);
        opacc(32'h0000_9000, 32'h0, 1'b0, 2'd0, 1'b0, "R8 set1 before arming");
        fetch(32'h0000_3000, 1'b0, "R8 level one via PC");
        opacc(32'h0000_9000, 32'h0, 1'b0, 2'd0, 1'b1, "R8 set1 fires level two");

        // R9: control rewrite clears armed level two
        fetch(32'h0000_3000, 1'b0, "R9 arm level two");
        cfg_write(15, 32'h0000_0047);
        opacc(32'h0000_9000, 32'h0, 1'b0, 2'd0, 1'b0, "R9 cleared by control write");

        // R9: disarmed
        cfg_write(15, 32'h0000_0046);
        fetch(32'h0000_1000, 1'b0, "R9 disarmed PC0");
        fetch(32'h0000_3000, 1'b0, "R9 disarmed PC2");

        // R10: mid-run reset clears registers
        cfg_write(15, 32'h0000_000D);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        fetch(32'h0000_1000, 1'b0, "R10 config cleared by reset");
        fetch(32'h0000_0000, 1'b0, "R10 disarmed after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule